// File: doc/BRIEF.md
# Oversampling Digital PLL for Receive Clock Recovery

This block rebuilds a receive sampling clock from a serial line by counting ticks of an oversampling strobe and locking its phase counter to transitions on the line. Two line codings are handled. In NRZI operation each bit lasts 32 ticks and every transition is taken as a cell boundary. In FM/Manchester operation each bit lasts 16 ticks, and only the clock transition at every second cell boundary is checked.

Software drives the block through 3-bit commands. They pick the coding, pick the tick source (baud generator or external clock/crystal), start an acquisition, or stop the loop. Two sticky flags report missed clock transitions in FM operation. After two successive misses the loop drops back into acquisition by itself.

All logic runs on one system clock. The selected tick source acts as a one-cycle enable. The line passes through a two-flop synchronizer before edge detection.

Top module: `dpll_recover`

## Requirements
- R1: After reset the coding is NRZI, the tick source is the external input (`xclk_tick`), the loop is stopped (line transitions are ignored), both miss flags are 0 and `rclk_out` is 1.
- R2: With `cmd_valid` high, `cmd` is decoded as follows: 001 starts an acquisition; 010 and 011 stop the loop; 100 selects `brg_tick`; 101 selects `xclk_tick`; 110 selects FM; 111 selects NRZI; 000 does nothing.
- R3: A change on `rxd_in` before clock edge k is acted on at edge k+2 when a tick is present. A transition seen while no tick is present is held until the next tick of the selected source. Ticks from the unselected source have no effect.
- R4: In NRZI operation `rclk_out` is 1 while acquiring. The first transition drives it to 0. It then rises 16 and 48 ticks after that transition: it is high for phase counts 16..31 of a 32-tick cell.
- R5: While tracking in NRZI, a transition that arrives k ticks late (1 ≤ k ≤ 15) delays the next rising edge by one tick. One that arrives k ticks early (1 ≤ k ≤ 16) advances it by one tick. One that arrives on time leaves it unchanged.
- R6: In FM operation `rclk_out` is 0 while acquiring. After the first transition it is high for counts 4..7 of every 8-tick half cell, so its first rise comes 4 ticks after that transition.
- R7: In FM operation a window of ±WIN_HALF ticks (default 2) is checked around every second cell boundary, starting 32 ticks after acquisition. A transition inside the window moves the next rising edge by one tick early or late, as in R5. Transitions outside the window, including mid-cell ones, are ignored.
- R8: A checked FM window that contains no transition sets `miss_one`. The flag stays set.
- R9: Two successive empty FM windows set `miss_two`, and the loop returns to acquisition. It then locks on the next transition without a command. `miss_two` set implies `miss_one` set.
- R10: Commands 001, 010 and 011 clear both flags. After 010 or 011 the loop ignores transitions until a 001 command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd | input | 3 | Command code |
| brg_tick | input | 1 | Oversampling strobe from the baud generator |
| xclk_tick | input | 1 | Oversampling strobe from the external clock or crystal |
| rxd_in | input | 1 | Asynchronous serial line |
| rclk_out | output | 1 | Recovered receive clock |
| miss_one | output | 1 | Sticky: one checked window was empty |
| miss_two | output | 1 | Sticky: two successive windows were empty |

## Verification
The hardest cases to reach are the tick-exact ones. These are an FM transition that lands on the very tick where the window opens or closes, and two back-to-back empty windows that force the loop back into acquisition.

The bench runs ticks on every cycle, so the phase is a known function of the cycle count since acquisition. Each trial starts with a fresh acquisition command and a first transition. It then places a single further transition at every offset across a band of ticks around the predicted boundary. Each trial compares the tick of the next `rclk_out` rise, and the miss flags after the window closes, with values derived from the offset.

// File: rtl/dpll_pkg.sv
package dpll_pkg;

    localparam int PH_W     = 5;
    localparam int PH_HALF  = 1 << (PH_W - 1);

    typedef enum logic [2:0] {
        CMD_NOP     = 3'd0,
        CMD_SEARCH  = 3'd1,
        CMD_CLRMISS = 3'd2,
        CMD_DISABLE = 3'd3,
        CMD_SRC_BRG = 3'd4,
        CMD_SRC_EXT = 3'd5,
        CMD_FM      = 3'd6,
        CMD_NRZI    = 3'd7
    } dpll_cmd_e;

    typedef enum logic [1:0] {
        ST_HOLD   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_TRACK  = 2'd2
    } dpll_state_e;

    typedef enum logic {
        LC_NRZI = 1'b0,
        LC_FM   = 1'b1
    } line_code_e;

    typedef enum logic {
        SRC_EXT = 1'b0,
        SRC_BRG = 1'b1
    } clk_src_e;

    typedef struct packed {
        logic go_search;
        logic go_hold;
    } ctl_pulse_t;

    // Phase after a transition seen at count pos: on time -> 0,
    // late (first half) -> one tick slower, early -> one tick faster.
    function automatic logic [PH_W-1:0] phase_adjust(input logic [PH_W-1:0] pos);
        if (pos == '0)
            return '0;
        else if (pos < PH_W'(PH_HALF))
            return pos - 1'b1;
        else
            return pos + 1'b1;
    endfunction

endpackage

// File: rtl/dpll_sync.sv
module dpll_sync
    import dpll_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic tick,
    input  logic discard,
    output logic edge_o
);
    logic s1, s2, s3, pend;
    logic edge_now;

    assign edge_now = s2 ^ s3;
    assign edge_o   = edge_now | pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1   <= 1'b0;
            s2   <= 1'b0;
            s3   <= 1'b0;
            pend <= 1'b0;
        end else begin
            s1 <= din;
            s2 <= s1;
            s3 <= s2;
            if (discard || tick)
                pend <= 1'b0;
            else if (edge_now)
                pend <= 1'b1;
        end
    end

    assert_tick_drains_R3: assert property (@(posedge clk) disable iff (rst)
        tick |=> !pend);

endmodule

// File: rtl/dpll_ctrl.sv
module dpll_ctrl
    import dpll_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [2:0] cmd,
    output line_code_e mode,
    output clk_src_e   src,
    output ctl_pulse_t pulse
);
    dpll_cmd_e code;
    assign code = dpll_cmd_e'(cmd);

    always_comb begin
        pulse.go_search = cmd_valid && (code == CMD_SEARCH);
        pulse.go_hold   = cmd_valid && (code == CMD_CLRMISS || code == CMD_DISABLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= LC_NRZI;
            src  <= SRC_EXT;
        end else if (cmd_valid) begin
            case (code)
                CMD_SRC_BRG: src  <= SRC_BRG;
                CMD_SRC_EXT: src  <= SRC_EXT;
                CMD_FM:      mode <= LC_FM;
                CMD_NRZI:    mode <= LC_NRZI;
                default:     ;
            endcase
        end
    end

    assert_src_brg_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd == 3'd4) |=> src == SRC_BRG);
    assert_mode_fm_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd == 3'd6) |=> mode == LC_FM);

endmodule

// File: rtl/dpll_core.sv
module dpll_core
    import dpll_pkg::*;
#(
    parameter int WIN_HALF = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       edge_i,
    input  line_code_e mode,
    input  ctl_pulse_t pulse,
    output logic       rclk,
    output logic       miss_one,
    output logic       miss_two
);
    localparam logic [PH_W-1:0] WIN_OPEN  = PH_W'((1 << PH_W) - WIN_HALF);
    localparam logic [PH_W-1:0] WIN_LAST  = PH_W'(WIN_HALF);
    localparam logic [PH_W-1:0] WIN_CLOSE = PH_W'(WIN_HALF + 1);

    dpll_state_e     state;
    logic [PH_W-1:0] cnt;
    logic [PH_W-1:0] pos;
    logic            armed, hit, consec;
    logic            in_win;

    assign pos    = cnt + 1'b1;
    assign in_win = (pos >= WIN_OPEN) || (pos <= WIN_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_HOLD;
            cnt      <= '0;
            armed    <= 1'b0;
            hit      <= 1'b0;
            consec   <= 1'b0;
            miss_one <= 1'b0;
            miss_two <= 1'b0;
        end else if (pulse.go_hold || pulse.go_search) begin
            state    <= pulse.go_hold ? ST_HOLD : ST_SEARCH;
            armed    <= 1'b0;
            hit      <= 1'b0;
            consec   <= 1'b0;
            miss_one <= 1'b0;
            miss_two <= 1'b0;
        end else if (tick) begin
            case (state)
                ST_SEARCH: begin
                    if (edge_i) begin
                        state  <= ST_TRACK;
                        cnt    <= '0;
                        armed  <= 1'b0;
                        hit    <= 1'b0;
                        consec <= 1'b0;
                    end
                end
                ST_TRACK: begin
                    if (mode == LC_NRZI) begin
                        cnt <= edge_i ? phase_adjust(pos) : pos;
                    end else begin
                        cnt <= (edge_i && in_win) ? phase_adjust(pos) : pos;
                        if (pos == WIN_OPEN) begin
                            armed <= 1'b1;
                            hit   <= edge_i;
                        end else if (edge_i && in_win) begin
                            hit <= 1'b1;
                        end
                        if (pos == WIN_CLOSE && armed) begin
                            armed <= 1'b0;
                            if (hit) begin
                                consec <= 1'b0;
                            end else begin
                                miss_one <= 1'b1;
                                if (consec) begin
                                    miss_two <= 1'b1;
                                    consec   <= 1'b0;
                                    state    <= ST_SEARCH;
                                end else begin
                                    consec <= 1'b1;
                                end
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        if (state != ST_TRACK)
            rclk = (mode == LC_NRZI);
        else if (mode == LC_NRZI)
            rclk = cnt[PH_W-1];
        else
            rclk = cnt[2];
    end

    assert_two_needs_one_R9: assert property (@(posedge clk) disable iff (rst)
        miss_two |-> miss_one);
    assert_two_reenters_search_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(miss_two) |-> state == ST_SEARCH);
    assert_cmd_clears_flags_R10: assert property (@(posedge clk) disable iff (rst)
        (pulse.go_search || pulse.go_hold) |=> (!miss_one && !miss_two));
    assert_hold_kept_R10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && !pulse.go_search) |=> state == ST_HOLD);
    assert_phase_step_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TRACK && tick && !edge_i && !pulse.go_search && !pulse.go_hold)
        |=> cnt == PH_W'($past(cnt) + 1'b1));

endmodule

// File: rtl/dpll_recover.sv
module dpll_recover
    import dpll_pkg::*;
#(
    parameter int WIN_HALF = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [2:0] cmd,
    input  logic       brg_tick,
    input  logic       xclk_tick,
    input  logic       rxd_in,
    output logic       rclk_out,
    output logic       miss_one,
    output logic       miss_two
);
    line_code_e mode;
    clk_src_e   src;
    ctl_pulse_t pulse;
    logic       tick;
    logic       line_edge;

    assign tick = (src == SRC_BRG) ? brg_tick : xclk_tick;

    dpll_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .mode      (mode),
        .src       (src),
        .pulse     (pulse)
    );

    dpll_sync u_sync (
        .clk     (clk),
        .rst     (rst),
        .din     (rxd_in),
        .tick    (tick),
        .discard (pulse.go_search | pulse.go_hold),
        .edge_o  (line_edge)
    );

    dpll_core #(.WIN_HALF(WIN_HALF)) u_core (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .edge_i   (line_edge),
        .mode     (mode),
        .pulse    (pulse),
        .rclk     (rclk_out),
        .miss_one (miss_one),
        .miss_two (miss_two)
    );

endmodule

// File: tb/tb_dpll_recover.sv
`timescale 1ns/1ps
module tb_dpll_recover;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd = 3'd0;
    logic       brg_tick = 1'b1;
    logic       xclk_tick = 1'b1;
    logic       rxd_in = 1'b0;
    logic       rclk_out, miss_one, miss_two;

    int checks = 0;
    int errors = 0;
    int n = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dpll_recover dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd(cmd),
        .brg_tick(brg_tick), .xclk_tick(xclk_tick), .rxd_in(rxd_in),
        .rclk_out(rclk_out), .miss_one(miss_one), .miss_two(miss_two)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int k);
        repeat (k) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic step_to(input int t);
        while (n < t) step(1);
    endtask

    task automatic send_cmd(input logic [2:0] c);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd = c;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd = 3'd0;
    endtask

    task automatic start_edge();
        rxd_in = ~rxd_in;
        n = 0;
    endtask

    task automatic next_rise(input int lim, output int at);
        logic p;
        p = rclk_out;
        at = -1;
        while (n < lim && at < 0) begin
            step(1);
            if (!p && rclk_out) at = n;
            p = rclk_out;
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            finish_run();
        end
    end

    initial begin
        int r1, r2;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1 rclk after reset", rclk_out, 1);
        chk("R1 miss_one after reset", miss_one, 0);
        chk("R1 miss_two after reset", miss_two, 0);
        start_edge();
        step(40);
        chk("R1 stopped after reset ignores edge", rclk_out, 1);

        // R1/R3: default source is external tick
        brg_tick = 1'b0;
        send_cmd(3'd1);
        step(4);
        start_edge();
        step(2);
        chk("R3 not yet acquired at cycle 2", rclk_out, 1);
        step(1);
        chk("R3 acquired at cycle 3 on ext source", rclk_out, 0);

        // R3: unselected source ticks do nothing, pending edge held
        send_cmd(3'd4);
        send_cmd(3'd1);
        step(4);
        start_edge();
        step(40);
        chk("R3 no acquisition without brg tick", rclk_out, 1);
        send_cmd(3'd5);
        step(1);
        chk("R3 held edge taken on first ext tick", rclk_out, 0);

        // R2: baud source works when selected
        brg_tick = 1'b1;
        xclk_tick = 1'b0;
        send_cmd(3'd4);
        send_cmd(3'd1);
        step(4);
        start_edge();
        step(3);
        chk("R2 brg source acquisition", rclk_out, 0);
        xclk_tick = 1'b1;
        send_cmd(3'd5);

        // R4: NRZI first and second sampling edges
        send_cmd(3'd1);
        step(4);
        chk("R4 NRZI search level", rclk_out, 1);
        start_edge();
        next_rise(30, r1);
        next_rise(60, r2);
        chk("R4 first rise at 16 ticks after edge", r1, 19);
        chk("R4 second rise at 48 ticks after edge", r2, 51);

        // R5: NRZI phase correction sweep
        for (int d = -12; d <= 12; d++) begin
            int at;
            int exp;
            send_cmd(3'd1);
            step(4);
            start_edge();
            step_to(32 + d);
            rxd_in = ~rxd_in;
            next_rise(80, at);
            exp = (d < 0) ? 50 : ((d == 0) ? 51 : 52);
            chk($sformatf("R5 NRZI rise with offset %0d", d), at, exp);
        end

        // R10: disable stops tracking and ignores edges
        send_cmd(3'd1);
        step(4);
        start_edge();
        step(5);
        send_cmd(3'd3);
        chk("R10 disable returns to idle level", rclk_out, 1);
        start_edge();
        step(40);
        chk("R10 edges ignored after disable", rclk_out, 1);
        send_cmd(3'd1);
        step(4);
        start_edge();
        step(3);
        chk("R10 search after disable acquires", rclk_out, 0);

        // R6/R8/R9: FM acquisition, then two empty windows
        send_cmd(3'd6);
        send_cmd(3'd1);
        step(4);
        chk("R6 FM search level", rclk_out, 0);
        start_edge();
        next_rise(12, r1);
        next_rise(20, r2);
        chk("R6 FM first rise 4 ticks after edge", r1, 7);
        chk("R6 FM second rise 12 ticks after edge", r2, 15);
        step_to(37);
        chk("R8 no miss before window closes", miss_one, 0);
        step_to(38);
        chk("R8 miss_one after empty window", miss_one, 1);
        chk("R9 miss_two still clear after one miss", miss_two, 0);
        step_to(69);
        chk("R9 miss_two clear before second close", miss_two, 0);
        step_to(70);
        chk("R9 miss_two after second empty window", miss_two, 1);
        step_to(75);
        chk("R9 search level after two misses", rclk_out, 0);
        start_edge();
        next_rise(12, r1);
        chk("R9 automatic reacquisition", r1, 7);
        chk("R8 miss_one stays set", miss_one, 1);

        // R10: clear command
        send_cmd(3'd2);
        chk("R10 miss_one cleared", miss_one, 0);
        chk("R10 miss_two cleared", miss_two, 0);

        // R7/R8: FM window sweep
        for (int d = -16; d <= 5; d++) begin
            int at;
            int exp;
            send_cmd(3'd1);
            step(4);
            start_edge();
            step_to(32 + d);
            rxd_in = ~rxd_in;
            if (d >= -2 && d <= 2) begin
                step_to(36);
                next_rise(45, at);
                exp = (d < 0) ? 38 : ((d == 0) ? 39 : 40);
                chk($sformatf("R7 FM rise with offset %0d", d), at, exp);
            end
            step_to(45);
            exp = (d >= -2 && d <= 2) ? 0 : 1;
            chk($sformatf("R8 FM miss with offset %0d", d), miss_one, exp);
        end

        // R2: back to NRZI
        send_cmd(3'd7);
        send_cmd(3'd1);
        step(2);
        chk("R2 NRZI command restores high idle level", rclk_out, 1);

        finished = 1'b1;
        finish_run();
    end
endmodule